// File: doc/BRIEF.md
# 1-Wire Timebase Tick Divider

This block derives the roughly 1 MHz timing tick that a 1-Wire bus master runs on from a system clock anywhere between 1 MHz and 128 MHz. Its ratio is set by one 8-bit setting register. The register has three fields: an enable bit, a two-bit select for an odd prescale factor (1, 3, 5 or 7) and a three-bit exponent for a following divide by a power of two. The total ratio is the prescale factor times 2^n. Host software picks the setting that suits its clock. The block only runs the two cascaded counters that the setting selects.

The register sits at one address of a small write bus and its value is always visible on a read-back port. Writing it restarts both counter stages, so the first tick after a change already follows the new ratio. The tick output is high for exactly one clock cycle per divided period. With a total ratio of one it is high on every cycle.

Top module: `owi_tick_divider`

## Requirements
- R1: A synchronous active-low reset clears the setting register to 0x00, so the read-back shows 0x00 and the tick stays low until a valid setting is written.
- R2: A write with the address equal to 4 stores bits 7 and 4:0 of the write data. Bits 6:5 are discarded and always read back as zero. The read-back port shows the stored register on every cycle.
- R3: A write to any other address changes neither the register nor the phase of the tick.
- R4: While bit 7 (enable) of the register is 0, the tick never goes high.
- R5: Bits 1:0 select the prescale factor: 00 gives 1, 01 gives 3, 10 gives 5 and 11 gives 7.
- R6: Bits 4:2 hold an exponent n from 0 to 7 that adds a further divide by 2^n after the prescaler.
- R7: With enable set, the tick period is D = prescale × 2^n cycles and the tick is high for one cycle of each period. For D = 1 the tick is high on every cycle.
- R8: An accepted write clears both counter stages. Counting the cycles after the write edge from 0, the tick is high exactly in cycles k with k mod D = D−1.
- R9: If a write arrives in a cycle where the tick is high, that tick is still produced, and counting restarts under the new setting from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe of the register bus |
| reg_addr | input | ADDR_W (3) | Write address; the setting register answers at 4 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current setting register value |
| tick_o | output | 1 | One-cycle timebase tick |

## Verification
A register write and a tick can coincide: the tick comes from counter state, while the write clears that state. The bench first runs a divide-by-3 setting up to the cycle where its tick is high. In that same cycle it writes a divide-by-5 setting. It then expects the tick to be high in that cycle and the new period to start at cycle index 0 after the write. A foreign-address write placed partway through a period must leave the old phase running unchanged. Every enabled and disabled setting is also swept, and each one is checked against the period computed in the bench.

// File: rtl/owi_div_pkg.sv
`timescale 1ns/1ps
package owi_div_pkg;
    localparam int REG_W  = 8;
    localparam int PRE_W  = 2;
    localparam int EXP_W  = 3;
    localparam int EN_POS = 7;
    // bits kept by a write: enable, exponent, prescale select
    localparam logic [REG_W-1:0] KEEP_MASK = 8'h9F;

    typedef struct packed {
        logic             en;
        logic [EXP_W-1:0] exp;
        logic [PRE_W-1:0] pre;
    } div_cfg_t;

    function automatic div_cfg_t decode_cfg(input logic [REG_W-1:0] raw);
        div_cfg_t c;
        c.en  = raw[EN_POS];
        c.exp = raw[PRE_W+EXP_W-1:PRE_W];
        c.pre = raw[PRE_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/owi_div_cfg_reg.sv
`timescale 1ns/1ps
module owi_div_cfg_reg
    import owi_div_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int REG_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  cfg_q,
    output logic              hit
);
    typedef struct packed {
        logic [REG_W-1:0] cfg;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = wr_en && (addr == ADDR_W'(REG_ADDR));
        if (hit) begin
            st_d.cfg = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    // R3: foreign-address write leaves the register unchanged
    a_r3_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr != ADDR_W'(REG_ADDR)) |=> cfg_q == $past(cfg_q));

    // R2: accepted write lands with reserved bits dropped
    a_r2_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_ADDR)) |=> cfg_q == ($past(wdata) & KEEP_MASK));
endmodule

// File: rtl/owi_div_prescaler.sv
`timescale 1ns/1ps
module owi_div_prescaler #(
    parameter int PRE_W = 2,
    localparam int CNT_W = PRE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [PRE_W-1:0] sel,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        // odd factor 2*sel+1, so the terminal count is 2*sel
        last = {sel, 1'b0};
        wrap = run && (st_q.cnt == last);
        st_d = st_q;
        if (clear || !run) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: count never passes the selected terminal value
    a_r5_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= {sel, 1'b0});

    // R8: write restarts the prescale stage
    a_r8_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0);
endmodule

// File: rtl/owi_div_pow2.sv
`timescale 1ns/1ps
module owi_div_pow2 #(
    parameter int EXP_W = 3,
    localparam int CNT_W = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             step,
    input  logic [EXP_W-1:0] exp,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pow_state_t;

    pow_state_t       st_d, st_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << exp) - 1'b1);
        tick = step && (st_q.cnt == mask);
        st_d = st_q;
        if (clear || !run) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: binary stage stays below 2^n
    a_r6_pow_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= mask);

    // R8: write restarts the binary stage
    a_r8_pow_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0);
endmodule

// File: rtl/owi_tick_divider.sv
`timescale 1ns/1ps
module owi_tick_divider
    import owi_div_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int REG_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              tick_o
);
    logic [REG_W-1:0] cfg_raw;
    logic             cfg_hit;
    div_cfg_t         cfg;
    logic             pre_wrap;
    int unsigned      ratio_now;

    owi_div_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) i_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(reg_wr_en),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .cfg_q(cfg_raw),
        .hit  (cfg_hit)
    );

    always_comb begin
        cfg       = decode_cfg(cfg_raw);
        ratio_now = (2 * int'(cfg.pre) + 1) << cfg.exp;
    end

    owi_div_prescaler #(
        .PRE_W(PRE_W)
    ) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cfg_hit),
        .run  (cfg.en),
        .sel  (cfg.pre),
        .wrap (pre_wrap)
    );

    owi_div_pow2 #(
        .EXP_W(EXP_W)
    ) i_pow (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cfg_hit),
        .run  (cfg.en),
        .step (pre_wrap),
        .exp  (cfg.exp),
        .tick (tick_o)
    );

    assign reg_rdata = cfg_raw;

    // R1: first cycle out of reset is idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (reg_rdata == 8'h00 && !tick_o));

    // R2: reserved bits read as zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:5] == 2'b00);

    // R4: no tick without enable
    a_r4_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> reg_rdata[EN_POS]);

    // R7: tick lasts one cycle when the ratio exceeds one
    a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !cfg_hit && ratio_now > 1) |=> !tick_o);
endmodule

// File: tb/test_owi_tick_divider.sv
`timescale 1ns/1ps
module test_owi_tick_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tick_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    owi_tick_divider i_owi_tick_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr_en(reg_wr_en),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tick_o   (tick_o)
    );

    function automatic int ratio_of(input logic [7:0] v);
        return (2 * int'(v[1:0]) + 1) << v[4:2];
    endfunction

    task automatic check_val(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // drive one write at the current falling edge, return one cycle later
    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // sample tick for cycle indices idx0 .. idx0+n-1 of a period D
    task automatic run_check(input int d, input bit en, input int idx0,
                             input int n, input string tag);
        int bad = 0;
        int bad_idx = 0;
        int bad_act = 0;
        int bad_exp = 0;
        for (int k = idx0; k < idx0 + n; k++) begin
            int e = (en && (k % d) == d - 1) ? 1 : 0;
            if (int'(tick_o) != e) begin
                if (bad == 0) begin
                    bad_idx = k;
                    bad_act = int'(tick_o);
                    bad_exp = e;
                end
                bad++;
            end
            @(negedge clk);
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: D=%0d cycle %0d tick actual %0d expected %0d (%0d mismatches)",
                     tag, d, bad_idx, bad_act, bad_exp, bad);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // write attempted during reset must be lost (R1)
        do_write(3'd4, 8'h81);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 reset readback", int'(reg_rdata), 8'h00);
        run_check(1, 1'b0, 0, 20, "R1 idle tick after reset");

        // sweep every setting, enabled: R2 R5 R6 R7 R8
        for (int s = 0; s < 32; s++) begin
            logic [7:0] v = 8'h80 | 8'(s);
            logic [7:0] wv = v | ((s % 2 == 1) ? 8'h60 : 8'h00);
            int d = ratio_of(v);
            do_write(3'd4, wv);
            check_val("R2 readback masks bits 6:5", int'(reg_rdata), int'(v));
            run_check(d, 1'b1, 0, 3 * d, "R5 R6 R7 R8 enabled period");
        end

        // same settings with enable clear: R4
        for (int s = 0; s < 32; s++) begin
            logic [7:0] v = 8'(s);
            do_write(3'd4, v);
            check_val("R4 readback disabled", int'(reg_rdata), int'(v));
            run_check(1, 1'b0, 0, 40, "R4 no tick while disabled");
        end

        // write coinciding with a tick: R9
        do_write(3'd4, 8'h81);
        run_check(3, 1'b1, 0, 2, "R9 lead-in");
        check_val("R9 tick in write cycle", int'(tick_o), 1);
        do_write(3'd4, 8'h82);
        run_check(5, 1'b1, 0, 15, "R9 restart under new ratio");

        // mid-period write restart: R8
        do_write(3'd4, 8'h8C);
        run_check(8, 1'b1, 0, 5, "R8 lead-in");
        do_write(3'd4, 8'h8C);
        run_check(8, 1'b1, 0, 24, "R8 restart mid period");

        // foreign-address writes: R3
        do_write(3'd4, 8'h85);
        run_check(6, 1'b1, 0, 2, "R3 lead-in");
        do_write(3'd3, 8'h80);
        run_check(6, 1'b1, 3, 20, "R3 phase kept after foreign write");
        check_val("R3 readback after foreign write", int'(reg_rdata), 8'h85);
        do_write(3'd5, 8'h00);
        check_val("R3 readback after second foreign write", int'(reg_rdata), 8'h85);

        // reset mid-run: R1
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 readback after reset", int'(reg_rdata), 8'h00);
        run_check(1, 1'b0, 0, 20, "R1 idle after second reset");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule